// File: doc/BRIEF.md
# Paged SPI Register Access Bridge

This block lets a host reach registers inside a slave device that sits on an SPI link and groups its registers into pages. The host presents a page number, a register address inside that page, a byte count and up to eight bytes of write data, then pulses one trigger with a read or write direction. The bridge turns that single command into the serial sequence the slave expects. When the page differs from the last one selected, it first sends a page-select frame. It then sends the register command frame. On a read, it polls the slave's status byte until data is ready and then fetches the data bytes.

The host sees three status outputs. `busy` covers the whole command. `done` is a one-cycle pulse when the command ends. `err` stays valid from that pulse until the next command. Read results appear on `rd_data`, least significant byte in the low bits. The slave accepts a write only when the byte count sent matches the register's real size. The bridge sends exactly the programmed count and leaves that check to the slave.

The FSM states are:
- `ST_IDLE`: waits for the trigger. A valid trigger goes to `ST_PAGE`, or straight to `ST_ACCESS` on a page hit. A bad length stays in `ST_IDLE`.
- `ST_PAGE`: sends the page-select frame, then goes to `ST_GAP`.
- `ST_ACCESS`: sends the register frame. A write then goes to `ST_FINISH`; a read goes to `ST_GAP`.
- `ST_POLL`: reads the status byte. On ready it goes to `ST_GAP`. When not ready it also goes to `ST_GAP`, unless the retries are used up, in which case it goes to `ST_FINISH`.
- `ST_FETCH`: shifts in the data bytes, then goes to `ST_FINISH`.
- `ST_GAP`: holds chip select high for a fixed number of cycles, then enters the saved next state.
- `ST_FINISH`: returns to `ST_IDLE` on the next cycle.

Top module: `paged_spi_bridge`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: A trigger whose 4-bit `cmd_len` is 0 or greater than 8 is refused. In the next cycle `done` and `err` are 1 and `busy` stays 0. No SPI frame is sent.
- R3: Before the register access, the bridge sends a page-select frame. Its bytes are opcode 0x61, address 0xFF and the page number. This frame is sent whenever no page has been selected since reset or the requested page differs from the last page selected.
- R4: When the requested page equals the last page selected, no page-select frame is sent.
- R5: A write sends one frame: opcode 0x61, the register address, then exactly `cmd_len` bytes of `cmd_wdata`, low byte first. The slave keeps the value only when that count equals the register size. A mismatched write leaves the old value readable.
- R6: A read sends opcode 0x60 and the register address. It then polls with frames of opcode 0x60, address 0xFE and one status byte until bit 0 of the status byte is 1. Finally it sends a frame of opcode 0x60 and address 0xF0 and takes `cmd_len` bytes into `rd_data`, low byte first. The unread upper bytes are 0.
- R7: If the status byte shows bit 0 clear on MAX_POLLS consecutive polls (default 8), the command ends with `err` set. With MAX_POLLS-1 not-ready answers the read still succeeds.
- R8: `busy` rises in the cycle after a valid trigger and stays high until the command ends. `done` pulses for one cycle exactly when `busy` falls. `err` is 0 for a successful command.
- R9: The SPI link works in mode 0, most significant bit first. `spi_sclk` is low whenever `spi_cs_n` is high, and chip select is high while the bridge is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_go | input | 1 | Command trigger, one cycle, taken only while idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_page | input | 8 | Target page |
| cmd_addr | input | 8 | Register address inside the page |
| cmd_len | input | 4 | Register byte count, 1 to 8 |
| cmd_wdata | input | 64 | Write bytes, byte 0 in bits 7:0 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Error result of the last command |
| rd_data | output | 64 | Read result |
| spi_cs_n | output | 1 | Slave select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to slave |
| spi_miso | input | 1 | Serial data from slave |

## Verification
A refused trigger is due one cycle after the sampling edge. The bench drives the trigger after a falling edge and checks `done`, `err` and `busy` at the next falling edge. For a valid command, `busy` is checked at that same falling edge, while `done`, `err` and `rd_data` are due only when the variable-length serial sequence ends. The bench therefore waits, sampling at falling edges, for the `done` pulse. It reads results in that cycle and confirms at the following falling edge that `done` has dropped. Page-select skipping and write acceptance are judged from frame counts and register contents in the bench's slave model, after each command has ended.

// File: rtl/pspi_pkg.sv
package pspi_pkg;
    localparam logic [7:0] OP_RD     = 8'h60;
    localparam logic [7:0] OP_WR     = 8'h61;
    localparam logic [7:0] ADDR_PAGE = 8'hFF;
    localparam logic [7:0] ADDR_STAT = 8'hFE;
    localparam logic [7:0] ADDR_DATA = 8'hF0;
    localparam int         RDY_BIT   = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAGE,
        ST_ACCESS,
        ST_POLL,
        ST_FETCH,
        ST_GAP,
        ST_FINISH
    } pspi_state_t;
endpackage

// File: rtl/pspi_byte_shifter.sv
module pspi_byte_shifter #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic          phase;
    logic [7:0]    sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            bitn  <= '0;
            phase <= 1'b0;
            sh    <= '0;
            rx    <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                sh    <= tx;
                cnt   <= '0;
                bitn  <= '0;
                phase <= 1'b0;
            end else if (busy) begin
                if (cnt == CW'(HALF - 1)) begin
                    cnt <= '0;
                    if (!phase) begin
                        phase <= 1'b1;
                        rx    <= {rx[6:0], miso};
                    end else begin
                        phase <= 1'b0;
                        sh    <= {sh[6:0], 1'b0};
                        bitn  <= bitn + 3'd1;
                        if (bitn == 3'd7) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    assign sclk = phase;
    assign mosi = sh[7];
endmodule

// File: rtl/pspi_page_track.sv
module pspi_page_track #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [PW-1:0] page_in,
    input  logic [PW-1:0] cmp_page,
    output logic          hit
);
    logic [PW-1:0] last_page;
    logic          valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_page <= '0;
            valid     <= 1'b0;
        end else if (upd) begin
            last_page <= page_in;
            valid     <= 1'b1;
        end
    end

    assign hit = valid && (last_page == cmp_page);
endmodule

// File: rtl/paged_spi_bridge.sv
module paged_spi_bridge
    import pspi_pkg::*;
#(
    parameter int HALF      = 2,
    parameter int GAP_CYC   = 4,
    parameter int MAX_POLLS = 8,
    parameter int MAX_BYTES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_go,
    input  logic                   cmd_write,
    input  logic [7:0]             cmd_page,
    input  logic [7:0]             cmd_addr,
    input  logic [3:0]             cmd_len,
    input  logic [8*MAX_BYTES-1:0] cmd_wdata,
    output logic                   busy,
    output logic                   done,
    output logic                   err,
    output logic [8*MAX_BYTES-1:0] rd_data,
    output logic                   spi_cs_n,
    output logic                   spi_sclk,
    output logic                   spi_mosi,
    input  logic                   spi_miso
);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam int PCW = $clog2(MAX_POLLS + 1);

    pspi_state_t state, nxt, ret_st, nxt_ret;

    logic                   write_q;
    logic [7:0]             page_q, addr_q;
    logic [3:0]             len_q, bidx, flen, didx;
    logic [8*MAX_BYTES-1:0] wdata_q, rbuf;
    logic [GW-1:0]          gap_cnt;
    logic [PCW-1:0]         poll_cnt;
    logic                   launched, done_q, err_q;
    logic                   sh_start, sh_busy, sh_done;
    logic [7:0]             sh_tx, sh_rx;
    logic                   in_frame, frame_end, bad_len, page_hit, accept;
    logic                   poll_ready, poll_last;

    assign bad_len    = (cmd_len == 4'd0) || (cmd_len > 4'(MAX_BYTES));
    assign accept     = (state == ST_IDLE) && cmd_go;
    assign in_frame   = (state == ST_PAGE) || (state == ST_ACCESS) ||
                        (state == ST_POLL) || (state == ST_FETCH);
    assign frame_end  = in_frame && sh_done && (bidx == flen - 4'd1);
    assign poll_ready = sh_rx[RDY_BIT];
    assign poll_last  = (poll_cnt == PCW'(MAX_POLLS - 1));
    assign sh_start   = in_frame && !launched;
    assign didx       = bidx - 4'd2;

    pspi_page_track #(.PW(8)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (state == ST_PAGE && frame_end),
        .page_in  (page_q),
        .cmp_page (cmd_page),
        .hit      (page_hit)
    );

    pspi_byte_shifter #(.HALF(HALF)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sh_start),
        .tx    (sh_tx),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .busy  (sh_busy),
        .done  (sh_done),
        .rx    (sh_rx)
    );

    // next state and gap return target
    always_comb begin
        nxt     = state;
        nxt_ret = ret_st;
        unique case (state)
            ST_IDLE:   if (cmd_go && !bad_len) nxt = page_hit ? ST_ACCESS : ST_PAGE;
            ST_PAGE:   if (frame_end) begin nxt = ST_GAP; nxt_ret = ST_ACCESS; end
            ST_ACCESS: if (frame_end) begin
                           if (write_q) nxt = ST_FINISH;
                           else begin nxt = ST_GAP; nxt_ret = ST_POLL; end
                       end
            ST_POLL:   if (frame_end) begin
                           if (poll_ready) begin nxt = ST_GAP; nxt_ret = ST_FETCH; end
                           else if (poll_last) nxt = ST_FINISH;
                           else begin nxt = ST_GAP; nxt_ret = ST_POLL; end
                       end
            ST_FETCH:  if (frame_end) nxt = ST_FINISH;
            ST_GAP:    if (gap_cnt == GW'(GAP_CYC - 1)) nxt = ret_st;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ret_st <= ST_IDLE;
        end else begin
            state  <= nxt;
            ret_st <= nxt_ret;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_q  <= 1'b0;
            page_q   <= '0;
            addr_q   <= '0;
            len_q    <= '0;
            wdata_q  <= '0;
            rbuf     <= '0;
            bidx     <= '0;
            gap_cnt  <= '0;
            poll_cnt <= '0;
            launched <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= (state == ST_FINISH) || (accept && bad_len);
            if (accept) begin
                err_q    <= bad_len;
                write_q  <= cmd_write;
                page_q   <= cmd_page;
                addr_q   <= cmd_addr;
                len_q    <= cmd_len;
                wdata_q  <= cmd_wdata;
                poll_cnt <= '0;
                if (!cmd_write && !bad_len) rbuf <= '0;
            end
            if (sh_start) launched <= 1'b1;
            if (in_frame && sh_done) begin
                launched <= 1'b0;
                bidx     <= frame_end ? 4'd0 : bidx + 4'd1;
                if (state == ST_FETCH && bidx >= 4'd2)
                    rbuf[{didx[2:0], 3'b000} +: 8] <= sh_rx;
            end
            if (state == ST_POLL && frame_end && !poll_ready) begin
                poll_cnt <= poll_cnt + PCW'(1);
                if (poll_last) err_q <= 1'b1;
            end
            gap_cnt <= (state == ST_GAP && nxt == ST_GAP) ? gap_cnt + GW'(1) : '0;
        end
    end

    // outputs
    always_comb begin
        sh_tx = 8'h00;
        flen  = 4'd2;
        unique case (state)
            ST_PAGE: begin
                flen  = 4'd3;
                sh_tx = (bidx == 4'd0) ? OP_WR : (bidx == 4'd1) ? ADDR_PAGE : page_q;
            end
            ST_ACCESS: begin
                flen  = write_q ? len_q + 4'd2 : 4'd2;
                sh_tx = (bidx == 4'd0) ? (write_q ? OP_WR : OP_RD) :
                        (bidx == 4'd1) ? addr_q : wdata_q[{didx[2:0], 3'b000} +: 8];
            end
            ST_POLL: begin
                flen  = 4'd3;
                sh_tx = (bidx == 4'd0) ? OP_RD : (bidx == 4'd1) ? ADDR_STAT : 8'h00;
            end
            ST_FETCH: begin
                flen  = len_q + 4'd2;
                sh_tx = (bidx == 4'd0) ? OP_RD : (bidx == 4'd1) ? ADDR_DATA : 8'h00;
            end
            default: begin
                flen  = 4'd2;
                sh_tx = 8'h00;
            end
        endcase
    end

    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign err      = err_q;
    assign rd_data  = rbuf;
    assign spi_cs_n = !in_frame;

    logic unused_ok;
    assign unused_ok = sh_busy;
endmodule

// File: rtl/pspi_checker.sv
module pspi_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_go,
    input logic [3:0] cmd_len,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       spi_cs_n,
    input logic       spi_sclk
);
    logic bad;
    assign bad = (cmd_len == 4'd0) || (cmd_len > 4'd8);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_cs_n && !spi_sclk));

    a_r2_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && !busy && bad) |=> (done && err && !busy));

    a_r8_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && !busy && !bad) |=> busy);

    a_r8_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_clock_idle: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);
endmodule

bind paged_spi_bridge pspi_checker u_pspi_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_go   (cmd_go),
    .cmd_len  (cmd_len),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .spi_cs_n (spi_cs_n),
    .spi_sclk (spi_sclk)
);

// File: tb/tb_paged_spi_bridge.sv
`timescale 1ns/1ps
module tb_paged_spi_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_go = 1'b0;
    logic        cmd_write = 1'b0;
    logic [7:0]  cmd_page = '0;
    logic [7:0]  cmd_addr = '0;
    logic [3:0]  cmd_len = '0;
    logic [63:0] cmd_wdata = '0;
    logic        busy, done, err;
    logic [63:0] rd_data;
    logic        spi_cs_n, spi_sclk, spi_mosi, spi_miso;

    always #2.5 clk = ~clk;

    paged_spi_bridge dut (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_write(cmd_write),
        .cmd_page(cmd_page), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .err(err),
        .rd_data(rd_data), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int total = 0;
    int bad = 0;

    // ---------------- slave model ----------------
    logic [63:0] smem [logic [15:0]];
    logic [7:0]  cur_page = 8'h00;
    logic [7:0]  in_sh = '0, out_sh = '0, next_out = '0;
    logic [7:0]  f_op = '0, f_addr = '0;
    logic [7:0]  f_data [0:15];
    logic [63:0] rd_latch = '0;
    int bitc = 0, byte_i = 0, polls_left = 0, poll_delay = 0;
    int page_frames = 0, all_frames = 0;

    function automatic int reg_size(input logic [7:0] a);
        return int'(a[2:0]) + 1;
    endfunction

    function automatic logic [63:0] len_mask(input int n);
        return (n >= 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * n)) - 64'd1);
    endfunction

    assign spi_miso = out_sh[7];

    always @(negedge spi_cs_n) begin
        bitc = 0;
        byte_i = 0;
    end

    always @(posedge spi_sclk) begin
        in_sh = {in_sh[6:0], spi_mosi};
        bitc++;
        if (bitc == 8) begin
            bitc = 0;
            if (byte_i == 0) f_op = in_sh;
            else if (byte_i == 1) f_addr = in_sh;
            else if (byte_i < 18) f_data[byte_i - 2] = in_sh;
            byte_i++;
            next_out = 8'h00;
            if (f_op == 8'h60 && byte_i >= 2) begin
                if (f_addr == 8'hFE) next_out = (polls_left == 0) ? 8'h01 : 8'h00;
                else if (f_addr == 8'hF0 && byte_i < 10) next_out = rd_latch[8*(byte_i-2) +: 8];
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (bitc == 0) out_sh = next_out;
        else out_sh = {out_sh[6:0], 1'b0};
    end

    always @(posedge spi_cs_n) begin
        if (rst_n) begin
            logic [63:0] v;
            all_frames++;
            if (f_op == 8'h61 && f_addr == 8'hFF && byte_i == 3) begin
                cur_page = f_data[0];
                page_frames++;
            end else if (f_op == 8'h61 && f_addr < 8'hF0 && byte_i >= 3) begin
                if (byte_i - 2 == reg_size(f_addr)) begin
                    v = '0;
                    for (int k = 0; k < byte_i - 2; k++) v[8*k +: 8] = f_data[k];
                    smem[{cur_page, f_addr}] = v;
                end
            end else if (f_op == 8'h60 && f_addr < 8'hF0 && byte_i == 2) begin
                rd_latch = smem.exists({cur_page, f_addr}) ? smem[{cur_page, f_addr}] : 64'd0;
                polls_left = poll_delay;
            end else if (f_op == 8'h60 && f_addr == 8'hFE && byte_i == 3) begin
                if (polls_left > 0) polls_left--;
            end
        end
    end

    // ---------------- bench helpers ----------------
    logic [63:0] emem [logic [15:0]];
    logic [7:0]  exp_page = 8'h00;
    bit          exp_page_valid = 1'b0;
    logic        got_err;
    logic [63:0] got_data;
    bit          timed_out = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input bit wr, input logic [7:0] pg, input logic [7:0] ad,
                           input logic [3:0] ln, input logic [63:0] wd);
        int wd_cnt;
        @(negedge clk);
        cmd_go = 1'b1; cmd_write = wr; cmd_page = pg; cmd_addr = ad;
        cmd_len = ln; cmd_wdata = wd;
        @(negedge clk);
        cmd_go = 1'b0;
        check("R8 busy after trigger", {63'd0, busy}, 64'd1);
        wd_cnt = 0;
        while (!done && wd_cnt < 5000) begin
            @(negedge clk);
            wd_cnt++;
        end
        if (!done) begin
            timed_out = 1'b1;
            check("R8 command end (watchdog)", 64'd0, 64'd1);
        end
        got_err = err;
        got_data = rd_data;
        check("R8 busy low at done", {63'd0, busy}, 64'd0);
        @(negedge clk);
        check("R8 done one cycle", {63'd0, done}, 64'd0);
    endtask

    task automatic do_write(input logic [7:0] pg, input logic [7:0] ad, input int ln,
                            input logic [63:0] wd);
        int pf;
        bit need_page;
        pf = page_frames;
        need_page = !(exp_page_valid && exp_page == pg);
        run_cmd(1'b1, pg, ad, 4'(ln), wd);
        check(need_page ? "R3 page frame sent" : "R4 page frame skipped",
              64'(page_frames - pf), need_page ? 64'd1 : 64'd0);
        exp_page = pg; exp_page_valid = 1'b1;
        check("R8 write err clear", {63'd0, got_err}, 64'd0);
        if (ln == reg_size(ad)) emem[{pg, ad}] = wd & len_mask(ln);
    endtask

    task automatic do_read(input logic [7:0] pg, input logic [7:0] ad, input int ln);
        logic [63:0] e;
        int pf;
        bit need_page;
        pf = page_frames;
        need_page = !(exp_page_valid && exp_page == pg);
        run_cmd(1'b0, pg, ad, 4'(ln), 64'd0);
        check(need_page ? "R3 page frame on read" : "R4 no page frame on read",
              64'(page_frames - pf), need_page ? 64'd1 : 64'd0);
        exp_page = pg; exp_page_valid = 1'b1;
        e = emem.exists({pg, ad}) ? emem[{pg, ad}] : 64'd0;
        check("R6 read err clear", {63'd0, got_err}, 64'd0);
        check("R6 read data", got_data, e & len_mask(ln));
    endtask

    task automatic do_reject(input logic [3:0] ln);
        int af;
        af = all_frames;
        @(negedge clk);
        cmd_go = 1'b1; cmd_write = 1'b1; cmd_page = 8'h77; cmd_len = ln;
        @(negedge clk);
        cmd_go = 1'b0;
        check("R2 reject done", {63'd0, done}, 64'd1);
        check("R2 reject err", {63'd0, err}, 64'd1);
        check("R2 reject not busy", {63'd0, busy}, 64'd0);
        repeat (40) @(negedge clk);
        check("R2 no SPI frame", 64'(all_frames - af), 64'd0);
        check("R2 still idle", {63'd0, busy}, 64'd0);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, 190000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", {63'd0, busy}, 64'd0);
        check("R1 done", {63'd0, done}, 64'd0);
        check("R1 err", {63'd0, err}, 64'd0);
        check("R1 cs_n", {63'd0, spi_cs_n}, 64'd1);
        check("R1 sclk", {63'd0, spi_sclk}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 length boundaries
        do_reject(4'd0);
        do_reject(4'd9);
        do_reject(4'd15);

        // R3 / R4 / R5 directed
        do_write(8'h03, 8'h05, 6, 64'h1122_3344_5566_7788);
        do_read(8'h03, 8'h05, 6);
        do_write(8'h03, 8'h05, 4, 64'hDEAD_BEEF_CAFE_F00D); // R5 size mismatch: not kept
        do_read(8'h03, 8'h05, 6);
        do_write(8'h04, 8'h07, 8, 64'hA5A5_0102_0304_5A5A);
        do_read(8'h04, 8'h07, 8);
        do_read(8'h04, 8'h07, 2);                            // R6 short read, upper bytes zero
        do_write(8'h03, 8'h00, 1, 64'h0000_0000_0000_00C3);
        do_read(8'h03, 8'h00, 1);

        // R7 poll limit boundaries
        poll_delay = 7;
        do_read(8'h04, 8'h07, 8);                            // R7 one below limit succeeds
        poll_delay = 8;
        run_cmd(1'b0, 8'h04, 8'h07, 4'd8, 64'd0);
        check("R7 poll limit err", {63'd0, got_err}, 64'd1);
        poll_delay = 2;

        // random mix
        for (int i = 0; i < 40; i++) begin
            logic [7:0] pg, ad;
            int ln;
            pg = 8'($urandom_range(0, 3));
            ad = 8'($urandom_range(0, 8'hEF));
            ln = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 8) : reg_size(ad);
            if ($urandom_range(0, 1) == 1)
                do_write(pg, ad, ln, {$urandom, $urandom});
            else
                do_read(pg, ad, $urandom_range(1, 8));
        end

        if (!timed_out) $display("  test done: total=%0d bad=%0d", total, bad);
        else $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule